// File: doc/BRIEF.md
# Serial Combination Lock Controller

The block opens a lock after a short secret code is keyed in one bit at a time. An operator first presses the user reset. For each code bit, the operator sets a one-bit key switch and then presses the enter button. After the last bit, the block raises either `unlock` or `error`. That output stays up until the next user reset. A wrong bit is not reported when it is entered. The block keeps accepting presses until the full code has been keyed, so the operator cannot tell which bit was wrong.

The code is held in a register, not wired into the state logic. A load strobe can replace the code, but only while the controller waits for the first bit of a fresh entry. Each press of the enter button is a handshake. The key bit is compared on the first cycle the button is seen high. Nothing more happens until the button has been seen low again, so a long press counts once. The code length is the parameter `CODE_LEN` (default 3), and the code after power-on reset is `DEFAULT_CODE`.

Top module: `serial_lock`

## Requirements
- R1: Code bits are checked in ascending index order. The first accepted press is compared with code bit 0, the second with bit 1, and the last with bit CODE_LEN-1. A press is accepted when the key bit is sampled on the first clock edge at which `enterBtn` is seen high.
- R2: If every accepted key bit matched its code bit, `unlock` goes high on the clock edge that samples the last press.
- R3: If any key bit differed, `error` goes high on the clock edge that samples the last press. Before that, both `unlock` and `error` stay low whatever bits are entered.
- R4: Once high, `unlock` or `error` stays high until `userReset`. Further presses and key changes do not affect either output.
- R5: `userReset` (synchronous, active high) returns the controller to the start of a fresh entry from any point, clearing both outputs on the next edge. It leaves the stored code unchanged.
- R6: A press holding `enterBtn` high for any number of cycles advances the entry by exactly one bit. The next bit is accepted only after `enterBtn` has been sampled low at least once.
- R7: A `loadStb` pulse writes `loadCode` into the code register only when no bit of the current entry has been accepted yet and `userReset` is low. Otherwise the pulse is ignored.
- R8: The asynchronous active-low `rstN` sets the code to `DEFAULT_CODE`, puts the controller at the start of an entry, and holds both outputs low.
- R9: `unlock` and `error` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| userReset | input | 1 | Operator reset button, synchronous, active high |
| enterBtn | input | 1 | Enter button level, high while pressed |
| keyBit | input | 1 | Key switch value for the current code bit |
| loadStb | input | 1 | Strobe that writes a new code |
| loadCode | input | CODE_LEN | New code value, bit 0 entered first |
| unlock | output | 1 | High after a fully matching entry |
| error | output | 1 | High after a complete entry with any mismatch |

## Verification
The bench builds the block with its defaults: CODE_LEN of 3 and DEFAULT_CODE of 3'b101. With only eight possible entered codes, every code can be tried against each loaded combination. Press and release lengths are drawn at random between one and several cycles. This exercises the one-bit-per-press rule, the delay of the error report to the final bit, and the refusal of loads outside the start of an entry.

// File: rtl/lock_pkg.sv
package lock_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;  // restart entry: index and mismatch flag to zero
    logic take;   // record current key bit comparison, advance index
    logic load;   // write new code
  } lock_strobe_t;

  typedef enum logic [1:0] {
    S_PRESS   = 2'd0,  // waiting for enter to go high
    S_RELEASE = 2'd1,  // waiting for enter to go low
    S_OPEN    = 2'd2,  // full match, unlock held
    S_FAULT   = 2'd3   // complete entry with mismatch, error held
  } lock_state_t;

endpackage

// File: rtl/lock_datapath.sv
module lock_datapath
  import lock_pkg::*;
#(
  parameter int CODE_LEN = 3,
  parameter logic [CODE_LEN-1:0] DEFAULT_CODE = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  lock_strobe_t        strb,
  input  logic                keyBit,
  input  logic [CODE_LEN-1:0] loadCode,
  output logic                bitBad,
  output logic                errSeen,
  output logic                firstBit,
  output logic                lastBit
);
  localparam int IDX_W = (CODE_LEN > 1) ? $clog2(CODE_LEN) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CODE_LEN - 1);

  logic [CODE_LEN-1:0] codeReg;
  logic [IDX_W-1:0]    bitIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeReg <= DEFAULT_CODE;
    end else if (strb.load) begin
      codeReg <= loadCode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx  <= '0;
      errSeen <= 1'b0;
    end else if (strb.clear) begin
      bitIdx  <= '0;
      errSeen <= 1'b0;
    end else if (strb.take) begin
      bitIdx  <= bitIdx + 1'b1;
      errSeen <= errSeen | bitBad;
    end
  end

  assign bitBad   = keyBit ^ codeReg[bitIdx];
  assign firstBit = (bitIdx == '0);
  assign lastBit  = (bitIdx == LAST_IDX);

endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import lock_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         userReset,
  input  logic         enterBtn,
  input  logic         loadStb,
  input  logic         bitBad,
  input  logic         errSeen,
  input  logic         firstBit,
  input  logic         lastBit,
  output lock_strobe_t strb,
  output logic         unlock,
  output logic         error
);
  lock_state_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_PRESS;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    if (userReset) begin
      nextState  = S_PRESS;
      strb.clear = 1'b1;
    end else begin
      case (state)
        S_PRESS: begin
          strb.load = loadStb & firstBit;
          if (enterBtn) begin
            if (lastBit) begin
              nextState = (errSeen | bitBad) ? S_FAULT : S_OPEN;
            end else begin
              strb.take = 1'b1;
              nextState = S_RELEASE;
            end
          end
        end
        S_RELEASE: if (!enterBtn) nextState = S_PRESS;
        default:   nextState = state;
      endcase
    end
  end

  assign unlock = (state == S_OPEN);
  assign error  = (state == S_FAULT);

endmodule

// File: rtl/serial_lock.sv
module serial_lock
  import lock_pkg::*;
#(
  parameter int CODE_LEN = 3,
  parameter logic [CODE_LEN-1:0] DEFAULT_CODE = 3'b101
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                userReset,
  input  logic                enterBtn,
  input  logic                keyBit,
  input  logic                loadStb,
  input  logic [CODE_LEN-1:0] loadCode,
  output logic                unlock,
  output logic                error
);
  lock_strobe_t strb;
  logic bitBad, errSeen, firstBit, lastBit;

  lock_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .userReset(userReset), .enterBtn(enterBtn),
    .loadStb(loadStb), .bitBad(bitBad), .errSeen(errSeen),
    .firstBit(firstBit), .lastBit(lastBit), .strb(strb),
    .unlock(unlock), .error(error)
  );

  lock_datapath #(.CODE_LEN(CODE_LEN), .DEFAULT_CODE(DEFAULT_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .keyBit(keyBit),
    .loadCode(loadCode), .bitBad(bitBad), .errSeen(errSeen),
    .firstBit(firstBit), .lastBit(lastBit)
  );

endmodule

// File: rtl/lock_checker.sv
module lock_checker (
  input logic clk,
  input logic rstN,
  input logic userReset,
  input logic enterBtn,
  input logic unlock,
  input logic error
);
  // R5
  user_reset_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    userReset |=> (!unlock && !error));

  // R4
  unlock_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (unlock && !userReset) |=> unlock);

  // R4
  error_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (error && !userReset) |=> error);

  // R2
  unlock_needs_press_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlock) |-> ($past(enterBtn) && !$past(userReset)));

  // R3
  error_needs_press_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(error) |-> ($past(enterBtn) && !$past(userReset)));

  // R9
  outputs_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(unlock && error));

endmodule

bind serial_lock lock_checker u_chk (
  .clk(clk), .rstN(rstN), .userReset(userReset), .enterBtn(enterBtn),
  .unlock(unlock), .error(error)
);

// File: tb/tb_serial_lock.sv
module tb_serial_lock;
  localparam int N = 3;
  localparam logic [N-1:0] DEF = 3'b101;

  logic clk = 1'b0, rstN = 1'b0, userReset = 1'b0, enterBtn = 1'b0;
  logic keyBit = 1'b0, loadStb = 1'b0;
  logic [N-1:0] loadCode = '0;
  logic unlock, error;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serial_lock #(.CODE_LEN(N), .DEFAULT_CODE(DEF)) dut (
    .clk(clk), .rstN(rstN), .userReset(userReset), .enterBtn(enterBtn),
    .keyBit(keyBit), .loadStb(loadStb), .loadCode(loadCode),
    .unlock(unlock), .error(error)
  );

  function automatic logic [1:0] expOut(logic [N-1:0] code, logic [N-1:0] entered);
    return (code == entered) ? 2'b10 : 2'b01;  // {unlock, error}
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {unlock,error} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic pulseReset();
    userReset = 1'b1;
    @(negedge clk);
    userReset = 1'b0;
  endtask

  task automatic loadNew(logic [N-1:0] v);
    loadStb = 1'b1; loadCode = v;
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  // press one bit: hold cycles high, gap cycles low
  task automatic pressBit(logic b, int hold, int gap);
    keyBit = b; enterBtn = 1'b1;
    repeat (hold) @(negedge clk);
    enterBtn = 1'b0;
    keyBit = ~b;
    repeat (gap) @(negedge clk);
  endtask

  // enter a full code, checking outputs stay low before the last press
  task automatic enterCode(logic [N-1:0] c, logic [N-1:0] code, bit randomLen);
    for (int i = 0; i < N; i++) begin
      int h = randomLen ? 1 + int'($urandom_range(0, 4)) : 1;
      int g = randomLen ? 1 + int'($urandom_range(0, 2)) : 1;
      pressBit(c[i], h, g);
      if (i < N - 1) check("R3 no early report", {unlock, error}, 2'b00);
      else check("R1 R2 R3 final result", {unlock, error}, expOut(code, c));
    end
  endtask

  initial begin
    logic [N-1:0] code;
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    check("R8 reset state", {unlock, error}, 2'b00);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 idle after reset", {unlock, error}, 2'b00);

    // R8: default code opens
    enterCode(DEF, DEF, 0);

    // R4: extra presses and key changes do not disturb held output
    pressBit(1'b0, 2, 1);
    pressBit(1'b1, 3, 2);
    check("R4 unlock held", {unlock, error}, 2'b10);

    // R5: reset clears output, code kept
    pulseReset();
    check("R5 reset clears", {unlock, error}, 2'b00);
    enterCode(3'b000, DEF, 0);
    check("R4 error held", {unlock, error}, 2'b01);
    pressBit(1'b1, 1, 1);
    check("R4 error held after press", {unlock, error}, 2'b01);

    // R7: load at start
    pulseReset();
    code = 3'b011;
    loadNew(code);
    // R1: all eight codes, random press lengths
    for (int e = 0; e < 8; e++) begin
      pulseReset();
      enterCode(N'(e), code, 1);
    end

    // R6: very long hold on each bit counts once
    pulseReset();
    pressBit(code[0], 9, 1);
    pressBit(code[1], 7, 3);
    check("R6 long holds no early report", {unlock, error}, 2'b00);
    pressBit(code[2], 5, 1);
    check("R6 long holds open", {unlock, error}, 2'b10);

    // R7: load mid-entry ignored
    pulseReset();
    pressBit(code[0], 1, 1);
    loadNew(3'b000);
    pressBit(code[1], 1, 1);
    pressBit(code[2], 1, 1);
    check("R7 mid-entry load ignored", {unlock, error}, 2'b10);

    // R7: load while userReset high ignored
    userReset = 1'b1; loadStb = 1'b1; loadCode = 3'b000;
    @(negedge clk);
    userReset = 1'b0; loadStb = 1'b0;
    enterCode(code, code, 0);

    // R7: load while held output ignored
    loadNew(3'b110);
    pulseReset();
    enterCode(code, code, 0);

    // R5: reset mid-entry after a wrong bit
    pulseReset();
    pressBit(~code[0], 2, 1);
    pulseReset();
    enterCode(code, code, 1);

    // random loads and entries
    for (int k = 0; k < 20; k++) begin
      logic [N-1:0] ent;
      pulseReset();
      code = N'($urandom_range(0, 7));
      loadNew(code);
      ent = ($urandom_range(0, 2) == 0) ? code : N'($urandom_range(0, 7));
      enterCode(ent, code, 1);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule